// File: doc/BRIEF.md
# Peak-Current Gate Pair Generator

This block drives the two gate signals of a synchronous boost stage that runs under peak current mode control. A free-running period counter opens each switching cycle. The low-side (primary) switch turns on after a short guard interval. It stays on until a digital trip input, which stands for the inductor current reaching its threshold, ends the on-time. After a programmed guard delay, the high-side (secondary) switch takes over for the rest of the cycle. Both the turn-off edge and the dead time follow the trip event, not a fixed compare value. After configuration the loop runs cycle by cycle with no software involvement.

A maximum-duty count acts as a backstop when no trip arrives. Each instance holds its own dead-time settings, so several switching pairs can each run with a different delay. Period, dead times and duty limit are copied into internal shadow registers at each period boundary. A status flag tells whether the current cycle's on-time was ended by a trip.

Top module: `pcm_gate_pwm`

## Requirements
- R1: While `rst_n` is low or `en` is low, `gate_pri_o`, `gate_sec_o` and `trip_flag_o` are all 0. The first period starts on the first clock edge at which `en` is sampled high.
- R2: `gate_pri_o` and `gate_sec_o` are never 1 in the same cycle.
- R3: A period lasts `period_i`+1 clocks. At its first clock the secondary goes low. Both gates then stay low for `dt_rise_i`+1 clocks, where `dt_rise_i` is an 8-bit clock count, before the primary goes high. With no trip and the duty limit not reached, the primary stays high until the period ends.
- R4: `trip_i` passes through a two-flop synchronizer. If `trip_i` is high at a rising edge while the primary is on, the primary goes low on the third rising edge, counting that edge as the first.
- R5: After the primary goes low, both gates stay low for `dt_fall_i`+1 clocks before the secondary goes high. The secondary then stays high until the next period starts. A dead-time setting of 0 still gives one clock with both gates low.
- R6: A synchronized trip is ignored while the primary is off, whether before its turn-on or after its on-time has ended. Only the first acted-on trip in a period has any effect.
- R7: If the period count (0 at period start) is at or above `duty_max_i` while the primary is on and no synchronized trip is present, the primary is forced off. The R5 sequence follows, and `trip_flag_o` stays 0.
- R8: If a synchronized trip and the duty limit arrive in the same clock, the trip takes priority and `trip_flag_o` is set.
- R9: `trip_flag_o` goes to 1 on the same clock as the trip-driven fall of the primary. It goes back to 0 at the first clock of the next period.
- R10: `period_i`, `dt_rise_i`, `dt_fall_i` and `duty_max_i` are sampled only at a period start. A change made in the middle of a period takes effect from the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low forces both gates off |
| period_i | input | PW (16) | Period length minus one, in clocks |
| dt_rise_i | input | DW (8) | Guard clocks before the primary turns on, minus one |
| dt_fall_i | input | DW (8) | Guard clocks before the secondary turns on, minus one |
| duty_max_i | input | PW (16) | Period count at which the primary is forced off |
| trip_i | input | 1 | Asynchronous peak-current trip |
| gate_pri_o | output | 1 | Primary (low-side) gate drive |
| gate_sec_o | output | 1 | Secondary (high-side) gate drive |
| trip_flag_o | output | 1 | Current period's on-time was ended by a trip |

## Verification
Two events can end the on-time: a synchronized trip and the duty-limit compare. They can land on the same clock. The bench arranges this by raising `trip_i` two clocks before the period count reaches `duty_max_i`. It then checks that the flag is set, which shows the trip won. It also moves the trip one clock later and checks that the duty limit ends the on-time with the flag clear. A behavioural reference model is compared on every clock for both gates and the flag. That comparison also covers the collision of a period restart with a pending dead time or trip.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
  typedef enum logic [2:0] {
    ST_OFF,
    ST_RDEAD,
    ST_PRI,
    ST_FDEAD,
    ST_SEC
  } phase_e;
endpackage

// File: rtl/pcm_trip_sync.sv
module pcm_trip_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_head
        assign sync_d[g] = din;
      end else begin : g_tail
        assign sync_d[g] = sync_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign dout = sync_q[STAGES-1];
endmodule

// File: rtl/pcm_period_timer.sv
module pcm_period_timer #(
  parameter int unsigned PW = 16,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [PW-1:0] period_i,
  input  logic [DW-1:0] dt_fall_i,
  input  logic [PW-1:0] duty_max_i,
  output logic          start_o,
  output logic          at_dmax_o,
  output logic [DW-1:0] fdt_o
);
  logic          run_q,  run_d;
  logic [PW-1:0] cnt_q,  cnt_d;
  logic [PW-1:0] per_q;
  logic [PW-1:0] dmax_q;
  logic [DW-1:0] fdt_q;
  logic          shadow_ld;

  // period boundary: first enabled clock or terminal count
  assign start_o   = en && (!run_q || (cnt_q == per_q));
  assign shadow_ld = start_o;
  assign at_dmax_o = (cnt_q >= dmax_q);
  assign fdt_o     = fdt_q;

  always_comb begin
    run_d = run_q;
    cnt_d = cnt_q;
    if (!en) begin
      run_d = 1'b0;
      cnt_d = '0;
    end else if (start_o) begin
      run_d = 1'b1;
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run_d;
      cnt_q <= cnt_d;
    end
  end

  // shadow copies, written only at a period boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q  <= '0;
      dmax_q <= '0;
      fdt_q  <= '0;
    end else if (shadow_ld) begin
      per_q  <= period_i;
      dmax_q <= duty_max_i;
      fdt_q  <= dt_fall_i;
    end
  end
endmodule

// File: rtl/pcm_phase_fsm.sv
module pcm_phase_fsm
  import pcm_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          start_i,
  input  logic          trip_i,
  input  logic          at_dmax_i,
  input  logic [DW-1:0] dt_rise_i,
  input  logic [DW-1:0] fdt_i,
  output logic          pri_o,
  output logic          sec_o,
  output logic          flag_o
);
  phase_e        st_q, st_d;
  logic [DW-1:0] dc_q, dc_d;
  logic          fl_q, fl_d;

  always_comb begin
    st_d = st_q;
    dc_d = dc_q;
    fl_d = fl_q;
    if (!en) begin
      st_d = ST_OFF;
      fl_d = 1'b0;
    end else if (start_i) begin
      st_d = ST_RDEAD;
      dc_d = dt_rise_i;
      fl_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_RDEAD: begin
          if (dc_q == '0) st_d = ST_PRI;
          else            dc_d = dc_q - 1'b1;
        end
        ST_PRI: begin
          if (trip_i) begin
            st_d = ST_FDEAD;
            dc_d = fdt_i;
            fl_d = 1'b1;
          end else if (at_dmax_i) begin
            st_d = ST_FDEAD;
            dc_d = fdt_i;
          end
        end
        ST_FDEAD: begin
          if (dc_q == '0) st_d = ST_SEC;
          else            dc_d = dc_q - 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_OFF;
      dc_q <= '0;
      fl_q <= 1'b0;
    end else begin
      st_q <= st_d;
      dc_q <= dc_d;
      fl_q <= fl_d;
    end
  end

  assign pri_o  = (st_q == ST_PRI);
  assign sec_o  = (st_q == ST_SEC);
  assign flag_o = fl_q;
endmodule

// File: rtl/pcm_gate_pwm.sv
module pcm_gate_pwm #(
  parameter int unsigned PW      = 16,
  parameter int unsigned DW      = 8,
  parameter int unsigned SYNC_N  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [PW-1:0] period_i,
  input  logic [DW-1:0] dt_rise_i,
  input  logic [DW-1:0] dt_fall_i,
  input  logic [PW-1:0] duty_max_i,
  input  logic          trip_i,
  output logic          gate_pri_o,
  output logic          gate_sec_o,
  output logic          trip_flag_o
);
  logic          trip_s;
  logic          start;
  logic          at_dmax;
  logic [DW-1:0] fdt;

  pcm_trip_sync #(.STAGES(SYNC_N)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (trip_i),
    .dout  (trip_s)
  );

  pcm_period_timer #(.PW(PW), .DW(DW)) i_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .period_i   (period_i),
    .dt_fall_i  (dt_fall_i),
    .duty_max_i (duty_max_i),
    .start_o    (start),
    .at_dmax_o  (at_dmax),
    .fdt_o      (fdt)
  );

  pcm_phase_fsm #(.DW(DW)) i_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .start_i   (start),
    .trip_i    (trip_s),
    .at_dmax_i (at_dmax),
    .dt_rise_i (dt_rise_i),
    .fdt_i     (fdt),
    .pri_o     (gate_pri_o),
    .sec_o     (gate_sec_o),
    .flag_o    (trip_flag_o)
  );
endmodule

// File: rtl/pcm_gate_pwm_chk.sv
module pcm_gate_pwm_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic gate_pri_o,
  input logic gate_sec_o,
  input logic trip_flag_o
);
  // R2
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_pri_o && gate_sec_o));

  // R1
  disabled_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!gate_pri_o && !gate_sec_o && !trip_flag_o));

  // R5
  sec_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_sec_o) |-> $past(!gate_pri_o));

  // R3
  pri_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_pri_o) |-> $past(!gate_sec_o));

  // R9
  flag_with_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trip_flag_o) |-> $fell(gate_pri_o));
endmodule

bind pcm_gate_pwm pcm_gate_pwm_chk i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .en          (en),
  .gate_pri_o  (gate_pri_o),
  .gate_sec_o  (gate_sec_o),
  .trip_flag_o (trip_flag_o)
);

// File: tb/test_pcm_gate_pwm.sv
module test_pcm_gate_pwm;
  logic        clk;
  logic        rst_n;
  logic        en;
  logic [15:0] period_i;
  logic [7:0]  dt_rise_i;
  logic [7:0]  dt_fall_i;
  logic [15:0] duty_max_i;
  logic        trip_i;
  logic        gate_pri_o;
  logic        gate_sec_o;
  logic        trip_flag_o;

  pcm_gate_pwm i_pcm_gate_pwm (
    .clk, .rst_n, .en, .period_i, .dt_rise_i, .dt_fall_i,
    .duty_max_i, .trip_i, .gate_pri_o, .gate_sec_o, .trip_flag_o
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // behavioural reference: phase 0 off, 1 rise guard, 2 primary, 3 fall guard, 4 secondary
  int m_run, m_cnt, m_ph, m_d, m_flag, m_per, m_fdt, m_dmax;
  bit m_s1, m_s2;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_cnt = 0; m_ph = 0; m_d = 0; m_flag = 0;
      m_per = 0; m_fdt = 0; m_dmax = 0; m_s1 = 0; m_s2 = 0;
    end else begin
      bit st, tr, am;
      st = en && (m_run == 0 || m_cnt == m_per);
      tr = m_s2;
      am = (m_cnt >= m_dmax);
      if (!en) begin
        m_run = 0; m_cnt = 0; m_ph = 0; m_flag = 0;
      end else if (st) begin
        m_run = 1; m_cnt = 0; m_ph = 1; m_d = dt_rise_i; m_flag = 0;
        m_per = period_i; m_fdt = dt_fall_i; m_dmax = duty_max_i;
      end else begin
        m_cnt++;
        case (m_ph)
          1: if (m_d == 0) m_ph = 2; else m_d--;
          2: if (tr) begin m_ph = 3; m_d = m_fdt; m_flag = 1; end
             else if (am) begin m_ph = 3; m_d = m_fdt; end
          3: if (m_d == 0) m_ph = 4; else m_d--;
          default: ;
        endcase
      end
      m_s2 = m_s1;
      m_s1 = trip_i;
    end
  end

  int o1 = -1, o2 = -1, o3 = -1;
  bit chg_pend = 0;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic run(string req, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(req, "gate_pri_o", gate_pri_o, (m_ph == 2) ? 1 : 0);
      chk(req, "gate_sec_o", gate_sec_o, (m_ph == 4) ? 1 : 0);
      chk(req, "trip_flag_o", trip_flag_o, m_flag);
      chk("R2", "overlap", gate_pri_o & gate_sec_o, 0);
      if (chg_pend && m_cnt == 10 && m_run == 1) begin
        period_i = 16'd50; dt_rise_i = 8'd2; dt_fall_i = 8'd6; duty_max_i = 16'd35;
        chg_pend = 0;
      end
      trip_i = en && m_run == 1 && (m_cnt == o1 || m_cnt == o2 || m_cnt == o3);
    end
  endtask

  task automatic cfg(int per, int rdt, int fdt, int dm, int a, int b, int c);
    period_i = 16'(per); dt_rise_i = 8'(rdt); dt_fall_i = 8'(fdt); duty_max_i = 16'(dm);
    o1 = a; o2 = b; o3 = c;
  endtask

  initial begin
    rst_n = 0; en = 0; trip_i = 0;
    cfg(30, 3, 4, 100, -1, -1, -1);
    repeat (3) begin
      @(negedge clk);
      chk("R1", "reset pri", gate_pri_o, 0);
      chk("R1", "reset sec", gate_sec_o, 0);
      chk("R1", "reset flag", trip_flag_o, 0);
    end
    rst_n = 1;
    run("R1", 4);
    en = 1;
    run("R3", 70);                              // no trip, no limit
    cfg(30, 3, 4, 100, 12, -1, -1); run("R4", 100);
    cfg(30, 3, 9, 100, 12, -1, -1); run("R5", 70);
    cfg(30, 0, 0, 100, 12, -1, -1); run("R5", 70);   // zero guards
    cfg(40, 8, 3, 100, 2, 20, 24);  run("R6", 90);   // early and repeated trips
    cfg(30, 3, 4, 15, -1, -1, -1);  run("R7", 70);   // duty limit alone
    cfg(30, 3, 4, 15, 13, -1, -1);  run("R8", 70);   // trip meets limit
    cfg(30, 3, 4, 15, 14, -1, -1);  run("R7", 70);   // limit one clock first
    cfg(30, 3, 4, 100, 10, -1, -1); run("R9", 40);
    cfg(30, 3, 4, 100, -1, -1, -1); run("R9", 70);   // flag clears
    cfg(30, 3, 4, 25, 20, -1, -1);
    chg_pend = 1;                               // mid-period reprogram
    run("R10", 150);
    en = 0; run("R1", 10);
    en = 1; cfg(25, 1, 2, 100, 9, -1, -1); run("R3", 60);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog all actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule